// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is a slave on a two-wire serial bus. It answers a master that reads and writes a byte-wide memory held in registers inside the block. The bus lines arrive as a clock input and a data input. The block pulls the data line low through a single output-enable. The system clock samples both bus lines through two-flop synchronisers. Start and Stop conditions are found from data-line edges while the bus clock is high.

A transaction opens with a control byte. Its four upper bits are a fixed device code, `1010`. The next three bits must match the three strap pins, and its lowest bit picks the direction. In a write, two word-address bytes follow, high byte first, and then one or more data bytes. Each data byte is stored at the pointer, and the pointer then moves on. A read streams bytes from the pointer, MSB first. It continues while the master acknowledges and ends on a master NACK. A repeated Start placed after the two address bytes turns the transaction into a random read.

The parameter `ADDR_W` sets how many word-address bits are kept. The default is 11, so the block holds 2K bytes. Setting it to 13 gives the full 8K range, and then the top three bits of the high address byte are ignored.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: While `rst_n` is low, and right after reset, `sda_oe` is 0 and the block is idle.
- R2: After a Start, the block acknowledges the control byte only when that byte meets both of these conditions:
  - its bits [7:4] are `1010`;
  - its bits [3:1] equal `sel_pins[2:1:0]`, with bit 3 compared against `sel_pins[2]`.
  The acknowledge is SDA held low for the whole ninth clock. On a mismatch the block acknowledges nothing more until the next Start.
- R3: With control bit 0 equal to 0 (write), the block acknowledges the high address byte, the low address byte and each data byte. Each data byte is written at the pointer, and the pointer then increments.
- R4: High-byte address bits at and above position `ADDR_W-8` are ignored. With the default `ADDR_W`, this is bits [7:3] of the high byte.
- R5: With control bit 0 equal to 1 (read), the block shifts out the byte at the pointer MSB first. The pointer then increments.
- R6: A master ACK (SDA low in the ninth clock) after a read byte makes the block send the next byte. The pointer wraps from `2**ADDR_W-1` to 0.
- R7: A master NACK followed by a Stop ends the read, and `sda_oe` is 0 afterwards.
- R8: A repeated Start after the two address bytes, followed by a read control byte, returns data starting at the address just loaded.
- R9: A read that starts with no address bytes continues from the pointer left by the previous transaction.
- R10: A Stop (SDA rising while SCL is high) that arrives part-way through a data byte drops that byte, and memory is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sel_pins | input | 3 | Strap pins compared with control bits [3:1] |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
Both parts of the control byte, the device code and the strap select, are corrupted one at a time. This shows that each field gates the acknowledge on its own. Write-then-random-read pairs run with random upper address bits and random data. Against a bench memory model, they separate correct address masking from aliasing or a misplaced high-byte field. A burst read across the top address, followed by a read with no address, tells wrap-around apart from overflow, and a persistent pointer apart from one that resets. A write cut off by a Stop after four bits shows whether partial bytes leak into memory.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W = 11,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_pins,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {B_CTRL, B_AHI, B_ALO, B_DATA} role_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  st_t        st;
  role_t      role;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [ADDR_W-1:0] ptr;
  logic       rd, mack_ok;
  logic [7:0] mem [DEPTH];

  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;

  wire        byte_in  = (st == S_RX) && scl_fall && (cnt == 4'd8);
  wire        ctrl_hit = (sh[7:4] == DEV_CODE) && (sh[3:1] == sel_pins);
  wire        byte_acc = (role != B_CTRL) || ctrl_hit;
  wire        wr_en    = byte_in && (role == B_DATA) && !start_det && !stop_det;
  wire [7:0]  rdata    = mem[ptr];
  wire [ADDR_W-1:0] ptr_nx = ptr + {{(ADDR_W-1){1'b0}}, 1'b1};
  wire        idle     = (st == S_IDLE);

  always_ff @(posedge clk)
    if (wr_en) mem[ptr] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; role <= B_CTRL; cnt <= 4'd0; sh <= 8'd0;
      ptr <= '0; rd <= 1'b0; mack_ok <= 1'b0; sda_oe <= 1'b0;
    end else if (start_det) begin
      st <= S_RX; role <= B_CTRL; cnt <= 4'd0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_in) begin
            if (byte_acc) begin
              st <= S_ACK;
              sda_oe <= 1'b1;
              case (role)
                B_CTRL: begin rd <= sh[0]; role <= B_AHI; end
                B_AHI:  begin ptr <= {sh[HI_W-1:0], ptr[7:0]}; role <= B_ALO; end
                B_ALO:  begin ptr <= {ptr[ADDR_W-1:8], sh}; role <= B_DATA; end
                default: ptr <= ptr_nx;
              endcase
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_ACK: if (scl_fall) begin
          cnt <= 4'd0;
          if (rd) begin
            st <= S_TX; sh <= rdata; ptr <= ptr_nx; sda_oe <= ~rdata[7];
          end else begin
            st <= S_RX; sda_oe <= 1'b0;
          end
        end
        S_TX: if (scl_fall) begin
          if (cnt == 4'd7) begin
            st <= S_MACK; sda_oe <= 1'b0;
          end else begin
            sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 4'd1;
          end
        end
        S_MACK: begin
          if (scl_rise) mack_ok <= ~sda_s;
          else if (scl_fall) begin
            cnt <= 4'd0;
            if (mack_ok) begin
              st <= S_TX; sh <= rdata; ptr <= ptr_nx; sda_oe <= ~rdata[7];
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
endmodule

module i2c_eeprom_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_s,
  input logic       sda_oe,
  input logic       idle,
  input logic [3:0] cnt
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !sda_oe);
  a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n) idle |-> !sda_oe);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= 4'd8);
  a_r5_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_s);
  a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && sda_s && !$past(sda_s)) |=> !sda_oe);
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
  .sda_oe(sda_oe), .idle(idle), .cnt(cnt)
);

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
  localparam int CLK_P  = 10;
  localparam int Q      = 8;
  localparam int ADDR_W = 11;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   nchk = 0, nerr = 0;
  logic [7:0] refm [DEPTH];
  bit         refv [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  i2c_eeprom_slave #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sel_pins(SEL), .sda_oe(sda_oe));

  function automatic logic [7:0] ctrl_b(input logic [2:0] s, input logic rw);
    return {4'b1010, s, rw};
  endfunction
  function automatic int eff(input int a);
    return a & (DEPTH - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q; repeat (Q) @(negedge clk); endtask
  task automatic start_c;
    sda_m = 1'b1; wait_q; scl_m = 1'b1; wait_q; sda_m = 1'b0; wait_q; scl_m = 1'b0; wait_q;
  endtask
  task automatic stop_c;
    sda_m = 1'b0; wait_q; scl_m = 1'b1; wait_q; sda_m = 1'b1; wait_q;
  endtask
  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; wait_q; scl_m = 1'b1; wait_q; s = sda_line; wait_q; scl_m = 1'b0; wait_q;
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask
  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    logic s;
    b = 8'd0;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, s); b = {b[6:0], s}; end
    clk_bit(~give_ack, s);
  endtask

  task automatic set_addr(input int a, input string req);
    logic ack;
    send_byte(ctrl_b(SEL, 1'b0), ack); chk(ack, "R2 ctrl ack", ack, 1);
    send_byte(a[15:8], ack);           chk(ack, {req, " hi ack"}, ack, 1);
    send_byte(a[7:0], ack);            chk(ack, {req, " lo ack"}, ack, 1);
  endtask

  task automatic wr_byte(input int a, input logic [7:0] d, input string req);
    logic ack;
    start_c; set_addr(a, "R3");
    send_byte(d, ack); chk(ack, {req, " data ack"}, ack, 1);
    stop_c;
    refm[eff(a)] = d; refv[eff(a)] = 1'b1;
  endtask

  task automatic rd_rand(input int a, input int n, input string req);
    logic ack; logic [7:0] b;
    start_c; set_addr(a, "R8");
    start_c;
    send_byte(ctrl_b(SEL, 1'b1), ack); chk(ack, "R8 read ctrl ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(b, k != n - 1);
      chk(b == refm[eff(a + k)], req, b, refm[eff(a + k)]);
    end
    stop_c; wait_q;
    chk(!sda_oe, "R7 release after stop", sda_oe, 0);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    logic ack, s; logic [7:0] b;
    int addrs [16];
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    chk(!sda_oe, "R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sda_oe, "R1 oe after reset", sda_oe, 0);

    start_c;
    send_byte({4'b1011, SEL, 1'b0}, ack); chk(!ack, "R2 bad code nack", ack, 0);
    send_byte(8'h00, ack);                chk(!ack, "R2 silent after miss", ack, 0);
    stop_c;
    start_c;
    send_byte(ctrl_b(SEL ^ 3'b010, 1'b0), ack); chk(!ack, "R2 bad select nack", ack, 0);
    stop_c;
    start_c;
    send_byte(ctrl_b(SEL ^ 3'b100, 1'b1), ack); chk(!ack, "R2 bad A2 nack", ack, 0);
    stop_c;

    wr_byte(16'h0123, 8'h5A, "R3");
    rd_rand(16'h0123, 1, "R5 readback");

    wr_byte(16'hFC56, 8'h3C, "R4");
    rd_rand(16'h0456, 1, "R4 upper bits ignored");

    // R10: Stop after four data bits leaves memory untouched
    start_c; set_addr(16'h0123, "R10");
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    stop_c;
    rd_rand(16'h0123, 1, "R10 partial byte dropped");

    wr_byte(DEPTH - 1, 8'hA1, "R6");
    wr_byte(0, 8'hB2, "R6");
    wr_byte(1, 8'hC3, "R6");
    wr_byte(2, 8'hD4, "R9");
    rd_rand(DEPTH - 1, 3, "R6 wrap burst");

    start_c;
    send_byte(ctrl_b(SEL, 1'b1), ack); chk(ack, "R9 ctrl ack", ack, 1);
    recv_byte(b, 1'b0);
    chk(b == 8'hD4, "R9 current address read", b, 8'hD4);
    stop_c;

    for (int i = 0; i < 16; i++) begin
      int a;
      a = int'($urandom_range(DEPTH - 1, 0)) | (int'($urandom_range(31, 0)) << ADDR_W);
      addrs[i] = a;
      wr_byte(a, 8'($urandom), "R3 random");
    end
    for (int i = 0; i < 16; i++) begin
      int a;
      a = eff(addrs[15 - i]);
      rd_rand(a, (refv[eff(a + 1)] ? 2 : 1), "R5 random read");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule